// File: doc/BRIEF.md
# I2C Packet Header Decoder and Byte Sequencer

This block sits between a transmit FIFO and an I2C byte engine. It pulls a three-word header from the FIFO. The first word identifies the packet: a format field that must be zero, a protocol marker, a packet number and a controller number. The second word gives the payload length minus one. The third word carries the target address and the per-transfer options. From these words the block emits an ordered stream of byte-level commands: start, optional start byte, optional high-speed master code, address, payload, and a final stop or bus hold.

For writes, the payload words that follow the header are split into bytes, lowest byte first, until the byte count is used up. The unused upper bytes of a trailing partial word are dropped. For reads, one read command is issued per byte, and the last one is flagged so that the engine answers it with NAK. The engine acknowledges every command with one response. A NAK on an address or write byte aborts the packet with a stop, unless the packet asked to carry on through NAKs. The block reports the outcome with one of three single-cycle pulses.

Top module: `pkt_hdr_seq`

## Requirements
- R1: The block pops a word only while `tx_empty` is low and waits in each header step while it is high. Once the first header word is popped, `pkt_id` shows its bits 23:16 and `ctrl_id` its bits 15:12, and both hold until the next first header word.
- R2: A first header word with bit 4 clear or a nonzero bits 31:28 marks a foreign packet. The block issues no command for it. It pops the other two header words and, for a write, ceil(count/4) payload words, then pulses `proto_err` for one cycle after the last of those pops.
- R3: The byte count of a packet is the second header word's bits [LEN_W-1:0] plus one.
- R4: Commands use these `cmd_op` codes: 0 start, 1 repeated start, 2 address byte, 3 write byte, 4 read byte, 5 stop, 6 hold bus, 7 raw byte. `cmd_byte` is zero for codes 0, 1, 5 and 6. The order is: start. Then, if word-2 bit 20 is set, raw 0x01 and a repeated start. Then, if bit 22 is set, raw {00001, word-2 bits 14:12} and a repeated start. Then the address bytes, the payload, and finally hold if bit 16 is set, otherwise stop.
- R5: With word-2 bit 18 clear, one address byte {word2[7:1], rd} is sent, where rd is bit 19. With bit 18 set, two are sent: {11110, word2[10:9], rd} and then word2[8:1].
- R6: Write byte k of a packet is bits 8*(k%4)+7 : 8*(k%4) of payload word k/4. A payload word is popped only when its first byte is due, so no word after the last one needed is read.
- R7: A read packet issues count read commands. `cmd_byte` bit 0 is 1 only on the last of them, and all other bits of `cmd_byte` are zero. No payload word is popped for a read.
- R8: A command stays on `cmd_op`/`cmd_byte` with `cmd_valid` high until `cmd_ready` accepts it. The next command is offered only after `rsp_valid` has answered the previous one.
- R9: A response with `rsp_nak` to an address or write byte, when word-2 bit 21 is clear, makes the next command a stop. `nak_err` pulses one cycle after that stop's response, no `pkt_done` follows, and no further word of the packet is popped. With bit 21 set, the NAK is ignored.
- R10: One cycle after the response to the final stop or hold, `pkt_done` pulses if word-2 bit 17 was set. If that bit was clear, no pulse occurs.
- R11: After reset, `cmd_valid`, `tx_pop` and the three event pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 32 | Head word of the transmit FIFO (show-ahead) |
| tx_empty | input | 1 | Transmit FIFO holds no word |
| tx_pop | output | 1 | Consume the head word this cycle |
| cmd_valid | output | 1 | A byte-engine command is offered |
| cmd_ready | input | 1 | Byte engine accepts the offered command |
| cmd_op | output | 3 | Command code (see R4) |
| cmd_byte | output | 8 | Byte sent with the command |
| rsp_valid | input | 1 | Byte engine finished the last accepted command |
| rsp_nak | input | 1 | That command saw NAK |
| pkt_done | output | 1 | Packet completed, one-cycle pulse |
| proto_err | output | 1 | Foreign packet discarded, one-cycle pulse |
| nak_err | output | 1 | Packet aborted on NAK, one-cycle pulse |
| pkt_id | output | 8 | Packet number of the latest header |
| ctrl_id | output | 4 | Controller number of the latest header |

## Verification
A command becomes visible on the command port in the cycle after the clock edge that samples the response to the previous command. It is consumed at the first edge where `cmd_ready` is high. Every event pulse appears in the cycle after the edge that samples the final response, or the final discarded pop. The bench records `tx_pop` and the handshake at each rising edge and does its comparing at the following falling edge. It checks each pulse exactly one falling edge after it released the final response. To test the wait on responses, it alternates response latency between one and two cycles and flags any handshake while a response is still owed.

// File: rtl/pkt_hdr_seq.sv
module pkt_hdr_seq #(
  parameter int LEN_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tx_data,
  input  logic        tx_empty,
  output logic        tx_pop,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [2:0]  cmd_op,
  output logic [7:0]  cmd_byte,
  input  logic        rsp_valid,
  input  logic        rsp_nak,
  output logic        pkt_done,
  output logic        proto_err,
  output logic        nak_err,
  output logic [7:0]  pkt_id,
  output logic [3:0]  ctrl_id
);
  localparam int CNT_W = LEN_W + 1;

  localparam logic [2:0] OP_START = 3'd0, OP_RESTART = 3'd1, OP_ADDR = 3'd2,
                         OP_WRITE = 3'd3, OP_READ = 3'd4, OP_STOP = 3'd5,
                         OP_HOLD = 3'd6, OP_RAW = 3'd7;

  typedef enum logic [3:0] {
    ST_W0, ST_W1, ST_W2, ST_DROP, ST_START, ST_SB, ST_SBRS, ST_HS,
    ST_HSRS, ST_A1, ST_A2, ST_DATA, ST_END, ST_ABORT, ST_RSP
  } st_t;

  st_t st, ret, nxt;
  logic [CNT_W-1:0] left;
  logic [31:0] wbuf;
  logic        wvalid;
  logic [1:0]  bidx;
  logic        f_hs, f_cont, f_sb, f_rd, f_ten, f_ie, f_rs;
  logic [9:0]  addr;
  logic [2:0]  maddr;
  logic        drop, chk, chk_n, aborting;
  logic        hs;

  assign hs = cmd_valid && cmd_ready;

  assign tx_pop = !tx_empty &&
                  (st == ST_W0 || st == ST_W1 || st == ST_W2 || st == ST_DROP ||
                   (st == ST_DATA && !f_rd && !wvalid));

  always_comb begin
    cmd_valid = 1'b1;
    cmd_op    = OP_START;
    cmd_byte  = 8'h00;
    case (st)
      ST_START: ;
      ST_SB: begin
        cmd_op   = OP_RAW;
        cmd_byte = 8'h01;
      end
      ST_SBRS, ST_HSRS: cmd_op = OP_RESTART;
      ST_HS: begin
        cmd_op   = OP_RAW;
        cmd_byte = {5'b00001, maddr};
      end
      ST_A1: begin
        cmd_op   = OP_ADDR;
        cmd_byte = f_ten ? {5'b11110, addr[9:8], f_rd} : {addr[6:0], f_rd};
      end
      ST_A2: begin
        cmd_op   = OP_ADDR;
        cmd_byte = addr[7:0];
      end
      ST_DATA: begin
        if (f_rd) begin
          cmd_op   = OP_READ;
          cmd_byte = {7'b0, left == CNT_W'(1)};
        end else begin
          cmd_op    = OP_WRITE;
          cmd_byte  = wbuf[{bidx, 3'b000} +: 8];
          cmd_valid = wvalid;
        end
      end
      ST_END:   cmd_op = f_rs ? OP_HOLD : OP_STOP;
      ST_ABORT: cmd_op = OP_STOP;
      default:  cmd_valid = 1'b0;
    endcase
  end

  always_comb begin
    chk_n = (st == ST_A1) || (st == ST_A2) || (st == ST_DATA && !f_rd);
    case (st)
      ST_START: nxt = f_sb ? ST_SB : (f_hs ? ST_HS : ST_A1);
      ST_SB:    nxt = ST_SBRS;
      ST_SBRS:  nxt = f_hs ? ST_HS : ST_A1;
      ST_HS:    nxt = ST_HSRS;
      ST_HSRS:  nxt = ST_A1;
      ST_A1:    nxt = f_ten ? ST_A2 : ST_DATA;
      ST_A2:    nxt = ST_DATA;
      ST_DATA:  nxt = (left == CNT_W'(1)) ? ST_END : ST_DATA;
      default:  nxt = ST_W0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_W0;
      ret <= ST_W0;
      left <= '0;
      wbuf <= '0;
      wvalid <= 1'b0;
      bidx <= '0;
      {f_hs, f_cont, f_sb, f_rd, f_ten, f_ie, f_rs} <= '0;
      addr <= '0;
      maddr <= '0;
      drop <= 1'b0;
      chk <= 1'b0;
      aborting <= 1'b0;
      pkt_done <= 1'b0;
      proto_err <= 1'b0;
      nak_err <= 1'b0;
      pkt_id <= '0;
      ctrl_id <= '0;
    end else begin
      pkt_done  <= 1'b0;
      proto_err <= 1'b0;
      nak_err   <= 1'b0;
      case (st)
        ST_W0: if (!tx_empty) begin
          pkt_id  <= tx_data[23:16];
          ctrl_id <= tx_data[15:12];
          drop    <= (tx_data[31:28] != 4'd0) || !tx_data[4];
          st      <= ST_W1;
        end
        ST_W1: if (!tx_empty) begin
          left <= CNT_W'(tx_data[LEN_W-1:0]) + CNT_W'(1);
          st   <= ST_W2;
        end
        ST_W2: if (!tx_empty) begin
          f_hs   <= tx_data[22];
          f_cont <= tx_data[21];
          f_sb   <= tx_data[20];
          f_rd   <= tx_data[19];
          f_ten  <= tx_data[18];
          f_ie   <= tx_data[17];
          f_rs   <= tx_data[16];
          maddr  <= tx_data[14:12];
          addr   <= tx_data[10:1];
          wvalid <= 1'b0;
          bidx   <= '0;
          aborting <= 1'b0;
          if (!drop) st <= ST_START;
          else if (tx_data[19]) begin
            proto_err <= 1'b1;
            st <= ST_W0;
          end else st <= ST_DROP;
        end
        ST_DROP: if (!tx_empty) begin
          if (left <= CNT_W'(4)) begin
            proto_err <= 1'b1;
            st <= ST_W0;
          end else left <= left - CNT_W'(4);
        end
        ST_RSP: if (rsp_valid) begin
          if (chk && rsp_nak && !f_cont) st <= ST_ABORT;
          else if (ret == ST_W0) begin
            st <= ST_W0;
            if (aborting) nak_err <= 1'b1;
            else pkt_done <= f_ie;
          end else st <= ret;
        end
        default: begin
          if (tx_pop) begin
            wbuf   <= tx_data;
            wvalid <= 1'b1;
          end
          if (hs) begin
            ret <= nxt;
            chk <= chk_n;
            st  <= ST_RSP;
            if (st == ST_ABORT) aborting <= 1'b1;
            if (st == ST_DATA) begin
              left <= left - CNT_W'(1);
              bidx <= bidx + 2'd1;
              if (bidx == 2'd3 || left == CNT_W'(1)) wvalid <= 1'b0;
            end
          end
        end
      endcase
    end
  end
endmodule

module pkt_hdr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_empty,
  input logic       tx_pop,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       rsp_valid,
  input logic       pkt_done,
  input logic       proto_err,
  input logic       nak_err
);
  // R1
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));
  // R6
  pop_idle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !cmd_valid);
  // R10
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(rsp_valid));
  // R9
  nak_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak_err |-> $past(rsp_valid));
  // R2
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_done, proto_err, nak_err}));
endmodule

bind pkt_hdr_seq pkt_hdr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .tx_pop(tx_pop),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .pkt_done(pkt_done),
  .proto_err(proto_err), .nak_err(nak_err)
);

// File: tb/pkt_hdr_seq_tb.sv
`timescale 1ns/1ps
module pkt_hdr_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] tx_data = '0;
  logic tx_empty = 1'b1, tx_pop;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic rsp_valid = 1'b0, rsp_nak = 1'b0;
  logic pkt_done, proto_err, nak_err;
  logic [7:0] pkt_id;
  logic [3:0] ctrl_id;

  pkt_hdr_seq u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] fifo[$];
  int exp_op[$];
  int exp_byte[$];
  string exp_tag[$];
  int exp_evt = 0;
  int nak_target = -1, cmd_idx = 0, drop_left = 0, left_snap = 0;
  bit pkt_fin = 1'b0, evt_due = 1'b0, pend = 1'b0, pend_nak = 1'b0, pend_final = 1'b0;
  int wait_ct = 0;
  logic popped_q = 1'b0, hs_q = 1'b0;
  logic [2:0] op_q = '0;
  logic [7:0] byte_q = '0;
  logic [7:0] pb[64];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic void upd();
    tx_empty = (fifo.size() == 0);
    tx_data  = tx_empty ? 32'h0 : fifo[0];
  endfunction

  function automatic void finish_pkt();
    left_snap = fifo.size();
    fifo.delete();
    upd();
    pkt_fin = 1'b1;
  endfunction

  always @(posedge clk) begin
    popped_q <= tx_pop;
    hs_q     <= cmd_valid && cmd_ready;
    op_q     <= cmd_op;
    byte_q   <= cmd_byte;
  end

  always @(negedge clk) begin
    int evv;
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    cmd_ready = (cyc % 5) != 2;
    rsp_valid = 1'b0;
    rsp_nak   = 1'b0;
    evv = {pkt_done, proto_err, nak_err};
    if (popped_q) begin
      void'(fifo.pop_front());
      upd();
    end
    if (evt_due) begin
      evt_due = 1'b0;
      chk(evv == (exp_evt == 1 ? 4 : exp_evt == 2 ? 1 : 0),
          exp_evt == 2 ? "R9 nak event" : "R10 completion event", evv,
          exp_evt == 1 ? 4 : exp_evt == 2 ? 1 : 0);
      finish_pkt();
    end else if (popped_q && drop_left > 0) begin
      drop_left--;
      if (drop_left == 0) begin
        chk(evv == 2, "R2 proto event", evv, 2);
        finish_pkt();
      end else if (evv != 0) chk(0, "R2 early event", evv, 0);
    end else if (evv != 0) chk(0, "R10 unexpected event", evv, 0);
    if (hs_q) begin
      if (exp_op.size() == 0) chk(0, "R4 unexpected command", op_q, 0);
      else begin
        string t;
        int eo, eb;
        eo = exp_op.pop_front(); eb = exp_byte.pop_front(); t = exp_tag.pop_front();
        chk(!pend, "R8 command before response", 1, 0);
        chk(op_q == eo[2:0] && byte_q == eb[7:0], t, {op_q, byte_q}, {eo[2:0], eb[7:0]});
        pend = 1'b1;
        pend_nak = (cmd_idx == nak_target);
        pend_final = (exp_op.size() == 0);
        wait_ct = cmd_idx % 2;
        cmd_idx++;
      end
    end
    if (pend) begin
      if (wait_ct == 0) begin
        rsp_valid = 1'b1;
        rsp_nak = pend_nak;
        pend = 1'b0;
        if (pend_final) evt_due = 1'b1;
      end else wait_ct--;
    end
  end

  task automatic push_cmd(input int op, input int b, input string t);
    exp_op.push_back(op); exp_byte.push_back(b); exp_tag.push_back(t);
  endtask

  task automatic run(input logic [31:0] w0, input logic [31:0] w2, input int n,
                     input int nak_i, input int seed, input string name);
    int nw, hdr, popped, exp_left, t;
    bit rd, ok, abort;
    logic [9:0] a;
    logic [31:0] w;
    @(posedge clk); #1;
    rd = w2[19]; ok = w0[4] && (w0[31:28] == 4'd0); a = w2[10:1];
    nw = rd ? 0 : (n + 3) / 4;
    for (int i = 0; i < n; i++) pb[i] = 8'(seed + i * 37);
    fifo.push_back(w0); fifo.push_back(32'hFFFF_0000 | 32'(n - 1)); fifo.push_back(w2);
    for (int k = 0; k < nw; k++) begin
      w = 32'hA5A5_A5A5;
      for (int b = 0; b < 4; b++) if (4 * k + b < n) w[8*b +: 8] = pb[4*k + b];
      fifo.push_back(w);
    end
    cmd_idx = 0; nak_target = nak_i; pkt_fin = 0; exp_left = 0; abort = 0; drop_left = 0;
    if (!ok) begin
      drop_left = 3 + nw; exp_evt = 3;
    end else begin
      push_cmd(0, 0, "R4 start");
      if (w2[20]) begin push_cmd(7, 1, "R4 start byte"); push_cmd(1, 0, "R4 restart"); end
      if (w2[22]) begin push_cmd(7, {5'b00001, w2[14:12]}, "R4 hs code"); push_cmd(1, 0, "R4 restart"); end
      if (w2[18]) begin
        push_cmd(2, {5'b11110, a[9:8], rd}, "R5 addr hi");
        push_cmd(2, a[7:0], "R5 addr lo");
      end else push_cmd(2, {a[6:0], rd}, "R5 addr");
      hdr = exp_op.size();
      for (int i = 0; i < n; i++)
        if (rd) push_cmd(4, (i == n - 1) ? 1 : 0, "R3 R7 read");
        else push_cmd(3, pb[i], "R3 R6 write");
      abort = (nak_i >= 0) && !w2[21];
      if (abort) begin
        while (exp_op.size() > nak_i + 1) begin
          void'(exp_op.pop_back()); void'(exp_byte.pop_back()); void'(exp_tag.pop_back());
        end
        push_cmd(5, 0, "R9 abort stop");
        exp_evt = 2;
        popped = (nak_i < hdr) ? 0 : (nak_i - hdr) / 4 + 1;
        exp_left = nw - popped;
      end else begin
        push_cmd(w2[16] ? 6 : 5, 0, "R4 end");
        exp_evt = w2[17] ? 1 : 0;
      end
    end
    upd();
    t = 0;
    while (!pkt_fin && t < 3000) begin @(posedge clk); t++; end
    chk(pkt_fin, {"R4 packet finished ", name}, pkt_fin, 1);
    chk(left_snap == exp_left, {"R6 R9 words left ", name}, left_snap, exp_left);
    chk(exp_op.size() == 0, {"R4 commands missing ", name}, exp_op.size(), 0);
    chk(pkt_id == w0[23:16] && ctrl_id == w0[15:12], {"R1 ids ", name},
        {pkt_id, ctrl_id}, {w0[23:16], w0[15:12]});
    exp_op.delete(); exp_byte.delete(); exp_tag.delete();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!cmd_valid && !tx_pop && !pkt_done && !proto_err && !nak_err, "R11 reset",
        {cmd_valid, tx_pop, pkt_done, proto_err, nak_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // w2: bit22 hs, 21 cont, 20 start byte, 19 read, 18 ten, 17 ie, 16 hold
    run(32'h0001_3010, 32'h0002_0000 | (32'h50 << 1), 6, -1, 3, "write7");
    run(32'h0005_1010, 32'h000B_0000 | (32'h2C << 1), 3, -1, 9, "read hold");
    run(32'h0007_2010, 32'h0004_0000 | (32'h2E5 << 1), 4, -1, 21, "write10 noie");
    run(32'h0009_0010, 32'h005A_5000 | (32'h11 << 1), 1, -1, 5, "sb hs read");
    run(32'h0011_1010, 32'h0002_0000 | (32'h33 << 1), 9, 1, 40, "nak addr");
    run(32'h0012_1010, 32'h0002_0000 | (32'h33 << 1), 9, 3, 41, "nak data");
    run(32'h0013_1010, 32'h0022_0000 | (32'h34 << 1), 5, 2, 42, "nak cont");
    run(32'h0014_1000, 32'h0002_0000 | (32'h35 << 1), 5, -1, 43, "proto bit4");
    run(32'h1015_1010, 32'h000A_0000 | (32'h36 << 1), 2, -1, 44, "proto size");
    run(32'h0016_F010, 32'h0002_0000 | (32'h7F << 1), 1, -1, 45, "write one");
    run(32'h0017_1010, 32'h0006_0000 | (32'h155 << 1), 8, -1, 46, "write10 read flag off");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule